// File: doc/BRIEF.md
# Shared Interrupt Source Conditioner

This block takes a parameterised set of shared interrupt inputs, brings them into the clock domain, and turns each one into a pending bit. Each source can be set to level or edge sensing, active high or active low, and for edge sources can be set to react to both transitions. A per-source enable mask decides which pending bits may request service. Software can raise or acknowledge edge events through a single event register.

Every source is routed to one output pin and to a set of destination processors. For each destination, one interrupt line per pin is the OR of all sources that are pending, enabled, validly mapped to that pin and selected for that destination. Software drives the block through a simple valid/address/write bus with 32-bit data and word addresses. A read returns its data one cycle after the request.

Top module: `shirq_cond`

## Requirements
- R1: After reset the polarity register (0x01) reads all ones in the low NUM_SRC bits. The trigger (0x02), dual-edge (0x03), mask (0x06) and pending (0x07) registers read zero, and every `dst_irq` bit is 0.
- R2: The read-only configuration word at 0x00 reads NUM_SRC/8-1 in bits [7:0] and NUM_DST-1 in bits [15:8], with all other bits zero. Writes to it have no effect.
- R3: A level source (trigger bit 0) has a pending bit equal to its input when its polarity bit is 1, and to the inverted input when its polarity bit is 0. A change at the input shows in the pending bit after three rising clock edges: two synchroniser stages and the pending register.
- R4: For an edge source (trigger bit 1), the pending bit is set by a rising input edge when polarity is 1 and by a falling edge when polarity is 0. The bit stays set after the input returns until it is cleared through the event register.
- R5: When an edge source has its dual-edge bit set, both rising and falling edges set pending whatever its polarity bit holds.
- R6: Writing to 0x04 sets the mask bits that are 1 in the data, and writing to 0x05 clears the mask bits that are 1 in the data. Zero data bits leave the mask unchanged. The mask reads back at 0x06.
- R7: A write to 0x08 addresses the source given by data bits [IDX_W-1:0], where IDX_W = clog2(NUM_SRC). With bit 31 = 1 it sets that source's pending bit, and with bit 31 = 0 it clears it, in the cycle after the write. It acts on edge sources only; a level source's pending bit is unaffected.
- R8: The pin map of source i is at 0x40+i, with bit 31 = valid and bits [PIN_W-1:0] = pin. The destination map of source i is at 0x80+i, where bit d selects destination d. `dst_irq[d*NUM_PIN+p]` is 1 exactly when some source is pending, enabled, validly mapped to pin p and has destination bit d set.
- R9: `bus_rdata` carries the addressed register one cycle after a read request. Unmapped addresses and the write-only addresses read zero.
- R10: The pending register reads at 0x07, and its bits at and above NUM_SRC read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| src_in | input | NUM_SRC | Raw shared interrupt inputs, asynchronous |
| bus_valid | input | 1 | Bus request valid |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 8 | Word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, one cycle after request |
| dst_irq | output | NUM_DST*NUM_PIN | Reduced interrupt lines, index d*NUM_PIN+p |

## Verification
Directed patterns check each sensing mode in turn. A single pulse on a level source measures the three-edge latency and shows active-low inversion. Rise and fall pairs on an edge source separate polarity-selected latching, holding after release, and dual-edge reaction. Event writes to level and edge sources show that software raise and acknowledge act only in edge mode. Valid and invalid pin maps, together with multi-destination masks, separate the routing terms. A random phase then toggles inputs sparsely while rewriting the configuration, the masks, the maps and the events, and compares every output line and pending read with a cycle model kept in the bench.

// File: rtl/shirq_pkg.sv
package shirq_pkg;
   localparam int ADDR_W = 8;
   localparam int DATA_W = 32;

   localparam logic [ADDR_W-1:0] A_CFG   = 8'h00;
   localparam logic [ADDR_W-1:0] A_POL   = 8'h01;
   localparam logic [ADDR_W-1:0] A_TRIG  = 8'h02;
   localparam logic [ADDR_W-1:0] A_DUAL  = 8'h03;
   localparam logic [ADDR_W-1:0] A_MSET  = 8'h04;
   localparam logic [ADDR_W-1:0] A_MCLR  = 8'h05;
   localparam logic [ADDR_W-1:0] A_MASK  = 8'h06;
   localparam logic [ADDR_W-1:0] A_PEND  = 8'h07;
   localparam logic [ADDR_W-1:0] A_EVT   = 8'h08;
   localparam logic [1:0]        PIN_WIN = 2'b01;   // 0x40..0x7F
   localparam logic [1:0]        DST_WIN = 2'b10;   // 0x80..0xBF

   localparam int EVT_SET_BIT = 31;
   localparam int MAP_VLD_BIT = 31;

   typedef struct packed {
      logic                fire;
      logic                set;
      logic [5:0]          idx;
   } evt_t;
endpackage

// File: rtl/shirq_sync.sv
module shirq_sync #(
   parameter int W      = 16,
   parameter int STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   logic [STAGES-1:0][W-1:0] chain;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain[0] <= '0;
      else        chain[0] <= d;
   end

   for (genvar s = 1; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) chain[s] <= '0;
         else        chain[s] <= chain[s-1];
      end
   end

   assign q = chain[STAGES-1];
endmodule

// File: rtl/shirq_detect.sv
module shirq_detect #(
   parameter int N     = 16,
   parameter int IDX_W = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [N-1:0]     s_now,
   input  logic [N-1:0]     pol,
   input  logic [N-1:0]     trig,
   input  logic [N-1:0]     dual,
   input  logic             evt_fire,
   input  logic             evt_set,
   input  logic [IDX_W-1:0] evt_idx,
   output logic [N-1:0]     pend
);
   logic [N-1:0] s_prev;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) s_prev <= '0;
      else        s_prev <= s_now;
   end

   for (genvar gi = 0; gi < N; gi++) begin : g_src
      logic active, rise, fall, hit, sw_set, sw_clr, p_q;

      assign active = pol[gi] ? s_now[gi] : ~s_now[gi];
      assign rise   = s_now[gi] & ~s_prev[gi];
      assign fall   = ~s_now[gi] & s_prev[gi];
      assign hit    = dual[gi] ? (rise | fall) : (pol[gi] ? rise : fall);
      assign sw_set = evt_fire &  evt_set & (int'(evt_idx) == gi);
      assign sw_clr = evt_fire & ~evt_set & (int'(evt_idx) == gi);

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)              p_q <= 1'b0;
         else if (!trig[gi])      p_q <= active;
         else if (hit || sw_set)  p_q <= 1'b1;
         else if (sw_clr)         p_q <= 1'b0;
      end

      assign pend[gi] = p_q;
   end
endmodule

// File: rtl/shirq_regs.sv
module shirq_regs
   import shirq_pkg::*;
#(
   parameter int N     = 16,
   parameter int D     = 2,
   parameter int PIN_W = 2,
   parameter int IDX_W = 4
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    bus_valid,
   input  logic                    bus_write,
   input  logic [ADDR_W-1:0]       bus_addr,
   input  logic [DATA_W-1:0]       bus_wdata,
   output logic [DATA_W-1:0]       bus_rdata,
   input  logic [N-1:0]            pend,
   output logic [N-1:0]            pol,
   output logic [N-1:0]            trig,
   output logic [N-1:0]            dual,
   output logic [N-1:0]            mask,
   output logic [N-1:0]            pin_vld,
   output logic [N-1:0][PIN_W-1:0] pin_sel,
   output logic [N-1:0][D-1:0]     dst_sel,
   output logic                    evt_fire,
   output logic                    evt_set,
   output logic [IDX_W-1:0]        evt_idx
);
   localparam logic [DATA_W-1:0] CFG_WORD = DATA_W'({8'(D-1), 8'(N/8-1)});

   logic        wr, rd, in_pin, in_dst;
   logic [5:0]  map_idx;
   logic [N-1:0] wbits;
   logic [DATA_W-1:0] rd_val;

   assign wr      = bus_valid &  bus_write;
   assign rd      = bus_valid & ~bus_write;
   assign map_idx = bus_addr[5:0];
   assign in_pin  = (bus_addr[7:6] == PIN_WIN) && (int'(map_idx) < N);
   assign in_dst  = (bus_addr[7:6] == DST_WIN) && (int'(map_idx) < N);
   assign wbits   = bus_wdata[N-1:0];

   assign evt_idx  = bus_wdata[IDX_W-1:0];
   assign evt_set  = bus_wdata[EVT_SET_BIT];
   assign evt_fire = wr && (bus_addr == A_EVT) && (int'(evt_idx) < N);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pol  <= '1;
         trig <= '0;
         dual <= '0;
         mask <= '0;
      end else if (wr) begin
         unique case (bus_addr)
            A_POL:   pol  <= wbits;
            A_TRIG:  trig <= wbits;
            A_DUAL:  dual <= wbits;
            A_MSET:  mask <= mask | wbits;
            A_MCLR:  mask <= mask & ~wbits;
            default: ;
         endcase
      end
   end

   for (genvar gi = 0; gi < N; gi++) begin : g_map
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            pin_vld[gi] <= 1'b0;
            pin_sel[gi] <= '0;
            dst_sel[gi] <= '0;
         end else if (wr && (int'(map_idx) == gi)) begin
            if (in_pin) begin
               pin_vld[gi] <= bus_wdata[MAP_VLD_BIT];
               pin_sel[gi] <= bus_wdata[PIN_W-1:0];
            end
            if (in_dst) dst_sel[gi] <= bus_wdata[D-1:0];
         end
      end
   end

   always_comb begin
      rd_val = '0;
      unique case (bus_addr)
         A_CFG:   rd_val = CFG_WORD;
         A_POL:   rd_val = DATA_W'(pol);
         A_TRIG:  rd_val = DATA_W'(trig);
         A_DUAL:  rd_val = DATA_W'(dual);
         A_MASK:  rd_val = DATA_W'(mask);
         A_PEND:  rd_val = DATA_W'(pend);
         default: begin
            for (int i = 0; i < N; i++) begin
               if (int'(map_idx) == i) begin
                  if (in_pin) begin
                     rd_val = DATA_W'(pin_sel[i]);
                     rd_val[MAP_VLD_BIT] = pin_vld[i];
                  end
                  if (in_dst) rd_val = DATA_W'(dst_sel[i]);
               end
            end
         end
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  bus_rdata <= '0;
      else if (rd) bus_rdata <= rd_val;
   end
endmodule

// File: rtl/shirq_route.sv
module shirq_route #(
   parameter int N     = 16,
   parameter int D     = 2,
   parameter int P     = 4,
   parameter int PIN_W = 2
) (
   input  logic [N-1:0]            act,
   input  logic [N-1:0]            pin_vld,
   input  logic [N-1:0][PIN_W-1:0] pin_sel,
   input  logic [N-1:0][D-1:0]     dst_sel,
   output logic [D*P-1:0]          irq
);
   for (genvar gd = 0; gd < D; gd++) begin : g_dst
      for (genvar gp = 0; gp < P; gp++) begin : g_pin
         logic [N-1:0] hits;
         for (genvar gi = 0; gi < N; gi++) begin : g_term
            assign hits[gi] = act[gi] & pin_vld[gi] & dst_sel[gi][gd] &
                              (pin_sel[gi] == PIN_W'(gp));
         end
         assign irq[gd*P+gp] = |hits;
      end
   end
endmodule

// File: rtl/shirq_cond.sv
module shirq_cond
   import shirq_pkg::*;
#(
   parameter int NUM_SRC     = 16,
   parameter int NUM_DST     = 2,
   parameter int NUM_PIN     = 4,
   parameter int SYNC_STAGES = 2
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic [NUM_SRC-1:0]         src_in,
   input  logic                       bus_valid,
   input  logic                       bus_write,
   input  logic [ADDR_W-1:0]          bus_addr,
   input  logic [DATA_W-1:0]          bus_wdata,
   output logic [DATA_W-1:0]          bus_rdata,
   output logic [NUM_DST*NUM_PIN-1:0] dst_irq
);
   localparam int PIN_W = (NUM_PIN > 1) ? $clog2(NUM_PIN) : 1;
   localparam int IDX_W = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1;

   if ((NUM_SRC % 8) != 0 || NUM_SRC < 8 || NUM_SRC > 32) begin : g_bad_src
      $error("NUM_SRC must be a multiple of 8 between 8 and 32");
   end
   if (NUM_DST < 1 || NUM_DST > 31) begin : g_bad_dst
      $error("NUM_DST must be between 1 and 31");
   end
   if (NUM_PIN < 1 || PIN_W > 31) begin : g_bad_pin
      $error("NUM_PIN out of range");
   end
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("SYNC_STAGES must be at least 2");
   end

   logic [NUM_SRC-1:0]            s_now, pend_q, pol_q, trig_q, dual_q, mask_q, pin_vld;
   logic [NUM_SRC-1:0][PIN_W-1:0] pin_sel;
   logic [NUM_SRC-1:0][NUM_DST-1:0] dst_sel;
   logic                          evt_fire, evt_set;
   logic [IDX_W-1:0]              evt_idx;

   shirq_sync #(.W(NUM_SRC), .STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n), .d(src_in), .q(s_now)
   );

   shirq_regs #(.N(NUM_SRC), .D(NUM_DST), .PIN_W(PIN_W), .IDX_W(IDX_W)) u_regs (
      .clk(clk), .rst_n(rst_n),
      .bus_valid(bus_valid), .bus_write(bus_write), .bus_addr(bus_addr),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .pend(pend_q), .pol(pol_q), .trig(trig_q), .dual(dual_q), .mask(mask_q),
      .pin_vld(pin_vld), .pin_sel(pin_sel), .dst_sel(dst_sel),
      .evt_fire(evt_fire), .evt_set(evt_set), .evt_idx(evt_idx)
   );

   shirq_detect #(.N(NUM_SRC), .IDX_W(IDX_W)) u_det (
      .clk(clk), .rst_n(rst_n), .s_now(s_now),
      .pol(pol_q), .trig(trig_q), .dual(dual_q),
      .evt_fire(evt_fire), .evt_set(evt_set), .evt_idx(evt_idx),
      .pend(pend_q)
   );

   shirq_route #(.N(NUM_SRC), .D(NUM_DST), .P(NUM_PIN), .PIN_W(PIN_W)) u_route (
      .act(pend_q & mask_q), .pin_vld(pin_vld), .pin_sel(pin_sel),
      .dst_sel(dst_sel), .irq(dst_irq)
   );
endmodule

// File: rtl/shirq_cond_chk.sv
module shirq_cond_chk
   import shirq_pkg::*;
#(
   parameter int N = 16,
   parameter int D = 2,
   parameter int P = 4
) (
   input logic              clk,
   input logic              rst_n,
   input logic              bus_valid,
   input logic              bus_write,
   input logic [ADDR_W-1:0] bus_addr,
   input logic [DATA_W-1:0] bus_wdata,
   input logic [D*P-1:0]    dst_irq,
   input logic [N-1:0]      pend,
   input logic [N-1:0]      mask,
   input logic [N-1:0]      trig
);
   localparam int IDX_W = (N > 1) ? $clog2(N) : 1;

   logic wr;
   logic [IDX_W-1:0] idx;
   assign wr  = bus_valid && bus_write;
   assign idx = bus_wdata[IDX_W-1:0];

   a_r6_mask_set: assert property (@(posedge clk) disable iff (!rst_n)
      (wr && bus_addr == A_MSET) |=>
      ((mask & $past(bus_wdata[N-1:0])) == $past(bus_wdata[N-1:0])));

   a_r6_mask_clr: assert property (@(posedge clk) disable iff (!rst_n)
      (wr && bus_addr == A_MCLR) |=> ((mask & $past(bus_wdata[N-1:0])) == '0));

   a_r6_mask_keep: assert property (@(posedge clk) disable iff (!rst_n)
      !(wr && (bus_addr == A_MSET || bus_addr == A_MCLR)) |=> $stable(mask));

   a_r8_gated: assert property (@(posedge clk) disable iff (!rst_n)
      (|dst_irq) |-> (|(pend & mask)));

   a_r7_evt_set: assert property (@(posedge clk) disable iff (!rst_n)
      (wr && bus_addr == A_EVT && bus_wdata[EVT_SET_BIT] && int'(idx) < N && trig[idx])
      |=> pend[$past(idx)]);

   for (genvar gi = 0; gi < N; gi++) begin : g_hold
      a_r4_edge_hold: assert property (@(posedge clk) disable iff (!rst_n)
         (trig[gi] && pend[gi] && !(wr && bus_addr == A_TRIG) &&
          !(wr && bus_addr == A_EVT && !bus_wdata[EVT_SET_BIT] && int'(idx) == gi))
         |=> pend[gi]);
   end
endmodule

bind shirq_cond shirq_cond_chk #(.N(NUM_SRC), .D(NUM_DST), .P(NUM_PIN)) u_chk (
   .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_write(bus_write),
   .bus_addr(bus_addr), .bus_wdata(bus_wdata), .dst_irq(dst_irq),
   .pend(pend_q), .mask(mask_q), .trig(trig_q)
);

// File: tb/tb_shirq_cond.sv
`timescale 1ns/1ps
module tb_shirq_cond;
   localparam int N = 16, D = 2, P = 4, PIN_W = 2, IDX_W = 4;

   logic clk = 0, rst_n = 0;
   logic [N-1:0] src_in = '0;
   logic bus_valid = 0, bus_write = 0;
   logic [7:0] bus_addr = '0;
   logic [31:0] bus_wdata = '0, bus_rdata;
   logic [D*P-1:0] dst_irq;

   always #4 clk = ~clk;

   shirq_cond #(.NUM_SRC(N), .NUM_DST(D), .NUM_PIN(P)) dut (.*);

   int errs = 0, checks = 0;
   bit done = 0, chk_en = 0, rnd_src = 0;

   logic [N-1:0] sh_pol = '1, sh_trig = '0, sh_dual = '0, sh_mask = '0, sh_vld = '0;
   logic [N-1:0][PIN_W-1:0] sh_pin = '0;
   logic [N-1:0][D-1:0] sh_dst = '0;
   logic [N-1:0] m_s1, m_s2, m_s3, m_pend, m_nxt;

   // Cycle model of the pending bits, built from R3, R4, R5, R7
   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         m_s1 <= '0; m_s2 <= '0; m_s3 <= '0; m_pend <= '0;
      end else begin
         m_nxt = m_pend;
         for (int i = 0; i < N; i++) begin
            if (!sh_trig[i]) m_nxt[i] = sh_pol[i] ? m_s2[i] : ~m_s2[i];
            else if ((sh_dual[i] ? (m_s2[i] != m_s3[i])
                                 : (sh_pol[i] ? (m_s2[i] & ~m_s3[i]) : (~m_s2[i] & m_s3[i]))) ||
                     (bus_valid && bus_write && bus_addr == 8'h08 && bus_wdata[31] &&
                      int'(bus_wdata[IDX_W-1:0]) == i))
               m_nxt[i] = 1'b1;
            else if (bus_valid && bus_write && bus_addr == 8'h08 && !bus_wdata[31] &&
                     int'(bus_wdata[IDX_W-1:0]) == i)
               m_nxt[i] = 1'b0;
         end
         m_pend <= m_nxt;
         m_s3 <= m_s2; m_s2 <= m_s1; m_s1 <= src_in;
      end
   end

   function automatic logic [D*P-1:0] exp_dst();
      logic [D*P-1:0] r = '0;
      for (int i = 0; i < N; i++)
         if (m_pend[i] && sh_mask[i] && sh_vld[i])
            for (int d = 0; d < D; d++)
               if (sh_dst[i][d]) r[d*P + int'(sh_pin[i])] = 1'b1;
      return r;
   endfunction

   task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         errs++;
         $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic shadow(input logic [7:0] a, input logic [31:0] w);
      case (a)
         8'h01: sh_pol = w[N-1:0];
         8'h02: sh_trig = w[N-1:0];
         8'h03: sh_dual = w[N-1:0];
         8'h04: sh_mask = sh_mask | w[N-1:0];
         8'h05: sh_mask = sh_mask & ~w[N-1:0];
         default: begin
            if (a[7:6] == 2'b01 && a[5:0] < N) begin
               sh_vld[a[3:0]] = w[31]; sh_pin[a[3:0]] = w[PIN_W-1:0];
            end
            if (a[7:6] == 2'b10 && a[5:0] < N) sh_dst[a[3:0]] = w[D-1:0];
         end
      endcase
   endtask

   task automatic wr(input logic [7:0] a, input logic [31:0] w);
      @(negedge clk);
      bus_valid = 1; bus_write = 1; bus_addr = a; bus_wdata = w;
      @(posedge clk); #1;
      shadow(a, w);
      @(negedge clk);
      bus_valid = 0; bus_write = 0;
   endtask

   task automatic rd(input logic [7:0] a, output logic [31:0] d);
      @(negedge clk);
      bus_valid = 1; bus_write = 0; bus_addr = a;
      @(negedge clk);
      d = bus_rdata; bus_valid = 0;
   endtask

   task automatic rd_chk(input logic [7:0] a, input logic [31:0] e, input string tag);
      logic [31:0] d;
      rd(a, d);
      chk(d == e, tag, d, e);
   endtask

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   always @(negedge clk)
      if (chk_en) chk(dst_irq == exp_dst(), "R8 dst_irq vs model", 32'(dst_irq), 32'(exp_dst()));

   always @(negedge clk)
      if (rnd_src) src_in <= src_in ^ (N'($urandom) & N'($urandom) & N'($urandom));

   initial begin
      #(8 * 150000);
      if (!done) begin
         errs++; checks++;
         $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
         $display("Result: errors=%0d of %0d checks", errs, checks);
         $finish;
      end
   end

   initial begin
      logic [31:0] d, e;
      void'($urandom(32'd4242));
      repeat (3) @(negedge clk);
      rst_n = 1;
      @(negedge clk);
      chk(dst_irq == '0, "R1 dst_irq after reset", 32'(dst_irq), 0);
      chk_en = 1;
      rd_chk(8'h01, 32'h0000_FFFF, "R1 polarity reset");
      rd_chk(8'h02, 32'h0, "R1 trigger reset");
      rd_chk(8'h03, 32'h0, "R1 dual reset");
      rd_chk(8'h06, 32'h0, "R1 mask reset");
      rd_chk(8'h07, 32'h0, "R1 pending reset");
      rd_chk(8'h00, 32'h0000_0101, "R2 config word");
      wr(8'h00, 32'hFFFF_FFFF);
      rd_chk(8'h00, 32'h0000_0101, "R2 config write ignored");
      rd_chk(8'h30, 32'h0, "R9 unmapped read");
      rd_chk(8'h04, 32'h0, "R9 write-only read");

      // R6 mask ports
      wr(8'h04, 32'h00F0); rd_chk(8'h06, 32'h00F0, "R6 mask set");
      wr(8'h04, 32'h0);    rd_chk(8'h06, 32'h00F0, "R6 zero set keeps");
      wr(8'h05, 32'h0030); rd_chk(8'h06, 32'h00C0, "R6 mask clear");
      wr(8'h05, 32'h0);    rd_chk(8'h06, 32'h00C0, "R6 zero clear keeps");
      wr(8'h05, 32'hFFFF); rd_chk(8'h06, 32'h0, "R6 clear all");

      // R3 level source 0 -> pin 1, destination 0
      wr(8'h40, 32'h8000_0001); wr(8'h80, 32'h1); wr(8'h04, 32'h1);
      @(negedge clk); src_in[0] = 1'b1;
      @(negedge clk); @(negedge clk);
      chk(dst_irq[1] == 1'b0, "R3 before third edge", 32'(dst_irq), 0);
      @(negedge clk);
      chk(dst_irq[1] == 1'b1, "R3 at third edge", 32'(dst_irq), 32'h2);
      wr(8'h08, 32'h0000_0000); idle(1);
      rd_chk(8'h07, 32'h1, "R7 clear ignored on level");
      wr(8'h01, 32'hFFFE); idle(4);
      rd_chk(8'h07, 32'h0, "R3 active-low high input");
      src_in[0] = 1'b0; idle(4);
      rd_chk(8'h07, 32'h1, "R3 active-low low input");
      wr(8'h01, 32'hFFFF); idle(4);
      rd_chk(8'h07, 32'h0, "R3 restore");

      // R4 edge source 1 -> pin 2, destination 1 (dst_irq[6])
      wr(8'h02, 32'h2); wr(8'h41, 32'h8000_0002); wr(8'h81, 32'h2); wr(8'h04, 32'h2);
      src_in[1] = 1'b1; idle(4);
      chk(dst_irq[6] == 1'b1, "R4 rising latches", 32'(dst_irq), 32'h40);
      src_in[1] = 1'b0; idle(4);
      chk(dst_irq[6] == 1'b1, "R4 holds after release", 32'(dst_irq), 32'h40);
      wr(8'h08, 32'h1); idle(1);
      chk(dst_irq[6] == 1'b0, "R4 event clear", 32'(dst_irq), 0);
      wr(8'h01, 32'hFFFD);
      src_in[1] = 1'b1; idle(4);
      chk(dst_irq[6] == 1'b0, "R4 rise ignored active-low", 32'(dst_irq), 0);
      src_in[1] = 1'b0; idle(4);
      chk(dst_irq[6] == 1'b1, "R4 fall latches active-low", 32'(dst_irq), 32'h40);
      wr(8'h08, 32'h1); idle(1);

      // R5 dual edge, polarity still low
      wr(8'h03, 32'h2);
      src_in[1] = 1'b1; idle(4);
      chk(dst_irq[6] == 1'b1, "R5 dual rise", 32'(dst_irq), 32'h40);
      wr(8'h08, 32'h1); idle(1);
      chk(dst_irq[6] == 1'b0, "R5 cleared", 32'(dst_irq), 0);
      src_in[1] = 1'b0; idle(4);
      chk(dst_irq[6] == 1'b1, "R5 dual fall", 32'(dst_irq), 32'h40);
      wr(8'h08, 32'h1); idle(1);

      // R7 software raise
      wr(8'h08, 32'h8000_0001); idle(1);
      chk(dst_irq[6] == 1'b1, "R7 event set edge source", 32'(dst_irq), 32'h40);
      rd_chk(8'h07, 32'h2, "R10 pending read after event");
      wr(8'h08, 32'h1);
      wr(8'h08, 32'h8000_0002); idle(1);
      rd_chk(8'h07, 32'h0, "R7 event set ignored on level");

      // R8 routing of level source 2 to both destinations
      wr(8'h42, 32'h0000_0003); wr(8'h82, 32'h3); wr(8'h04, 32'h4);
      src_in[2] = 1'b1; idle(4);
      chk(dst_irq == '0, "R8 invalid pin map", 32'(dst_irq), 0);
      wr(8'h42, 32'h8000_0003); idle(1);
      chk(dst_irq == 8'h88, "R8 both destinations", 32'(dst_irq), 32'h88);
      rd_chk(8'h42, 32'h8000_0003, "R8 pin map readback");
      wr(8'h82, 32'h0); idle(1);
      chk(dst_irq == '0, "R8 no destination", 32'(dst_irq), 0);

      // Random phase
      rnd_src = 1;
      for (int k = 0; k < 1500; k++) begin
         int op;
         logic [31:0] w;
         op = int'($urandom % 10);
         w = $urandom;
         case (op)
            0: wr(8'h01 + 8'($urandom % 3), 32'(w[N-1:0]));
            1: wr(8'h04, 32'(w[N-1:0] & N'($urandom)));
            2: wr(8'h05, 32'(w[N-1:0] & N'($urandom)));
            3: wr(8'h40 + 8'($urandom % N), w & 32'h8000_0003);
            4: wr(8'h80 + 8'($urandom % N), w & 32'h3);
            5: wr(8'h08, w & 32'h8000_000F);
            6: begin
               @(negedge clk);
               bus_valid = 1; bus_write = 0; bus_addr = 8'h07;
               e = 32'(m_pend);
               @(negedge clk);
               d = bus_rdata; bus_valid = 0;
               chk(d == e, "R10 random pending read", d, e);
            end
            7: rd_chk(8'h06, 32'(sh_mask), "R6 random mask read");
            default: idle(1);
         endcase
      end
      rnd_src = 0;
      idle(4);
      done = 1;
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
   end
endmodule